// File: doc/BRIEF.md
# Palette RAM Byte-Serial Access Port

This block gives an 8-bit host a way into a color palette of 256 entries, each 24 bits wide. One address register sets where writes go and another sets where reads come from. A single byte-wide data register carries the color bytes, and each palette entry takes three data accesses in the order red, green, blue. Written bytes are gathered in a staging buffer. The entry reaches the palette only when the blue byte arrives. After that the write address advances, so software can stream one entry after another.

On the read side, loading the read address fetches that entry into a holding register straight away and advances the read address. Data reads then hand out the held entry one byte at a time. After the blue byte has been read, the entry at the current read address is fetched and the address advances again. The palette also has an independent synchronous lookup port, used by the pixel path, which returns an entry one cycle after its index is applied.

Host accesses are single-cycle strobes qualified by chip select. A 2-bit select picks the register: 0 is the write address, 1 is the color data, 2 is the read address and 3 is reserved.

Top module: `palette_port`

## Requirements
- R1: After reset, `host_dout` is 0, both address registers read back 0, and both byte-phase counters are at red.
- R2: A host write with select 0 loads the write address. Reading select 0 returns the current write address.
- R3: Three data writes (select 1) commit {first, second, third} as bits [23:16], [15:8] and [7:0] of the entry at the write address, in the cycle of the third write. The write address then increments by one.
- R4: A partly gathered entry (one or two data bytes) is never committed. Writing the write address discards those bytes and restarts the phase at red.
- R5: A host write with select 2 fetches the entry at the written value into the holding register and sets the read address to that value plus one. The read phase restarts at red. Reading select 2 returns the read address.
- R6: Consecutive data reads return bits [23:16], [15:8] and [7:0] of the held entry. After the third read, the entry at the read address is fetched and the read address increments, so entries stream in order.
- R7: Both address registers wrap from 255 to 0 on increment.
- R8: Read data appears on `host_dout` in the cycle after the read strobe and holds its value until the next read strobe.
- R9: The lookup port returns the entry addressed by `pix_index` one clock later, independently of host activity.
- R10: Select 3 reads as 0, and writes to it change no address, phase or palette entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Chip select qualifying the strobes |
| host_rd | input | 1 | Single-cycle read strobe |
| host_wr | input | 1 | Single-cycle write strobe (wins over read) |
| host_sel | input | 2 | Register select: 0 write addr, 1 data, 2 read addr, 3 reserved |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Registered host read data |
| pix_index | input | 8 | Lookup port palette index |
| pix_color | output | 24 | Lookup port entry, one cycle after the index |

## Verification
The bench checks that two bytes followed by an address rewrite leave the old entry untouched. A design that committed partial data, or kept stale red and green bytes, would show a mixed entry on the lookup port. It checks that the read address reads back one past the loaded value, which catches a missing prefetch or an increment applied too late. Streaming across index 255 checks the wrap in both directions: an address that did not wrap would fetch or commit the wrong entry. Idle cycles between reads check that `host_dout` holds its value rather than following the holding register.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam logic [1:0] SEL_WADDR = 2'd0;
  localparam logic [1:0] SEL_DATA  = 2'd1;
  localparam logic [1:0] SEL_RADDR = 2'd2;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_t;
endpackage

// File: rtl/palette_ram.sv
module palette_ram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] w_addr,
  input  logic [DW-1:0] w_data,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[w_addr] <= w_data;
  end

  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/palette_wr_gather.sv
module palette_wr_gather
  import palette_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addr_we,
  input  logic [AW-1:0]   addr_in,
  input  logic            data_we,
  input  logic [BW-1:0]   data_in,
  output logic [AW-1:0]   addr,
  output phase_t          phase,
  output logic            ram_we,
  output logic [3*BW-1:0] ram_wdata
);
  logic [BW-1:0] red_q, green_q;

  assign ram_we    = data_we && (phase == PH_BLUE);
  assign ram_wdata = {red_q, green_q, data_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      phase   <= PH_RED;
      red_q   <= '0;
      green_q <= '0;
    end else if (addr_we) begin
      addr  <= addr_in;
      phase <= PH_RED;
    end else if (data_we) begin
      unique case (phase)
        PH_RED: begin
          red_q <= data_in;
          phase <= PH_GREEN;
        end
        PH_GREEN: begin
          green_q <= data_in;
          phase   <= PH_BLUE;
        end
        default: begin
          addr  <= addr + 1'b1;
          phase <= PH_RED;
        end
      endcase
    end
  end
endmodule

// File: rtl/palette_rd_prefetch.sv
module palette_rd_prefetch
  import palette_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addr_we,
  input  logic [AW-1:0]   addr_in,
  input  logic            data_re,
  input  logic [3*BW-1:0] held,
  output logic [AW-1:0]   addr,
  output phase_t          phase,
  output logic            fetch_en,
  output logic [AW-1:0]   fetch_addr,
  output logic [BW-1:0]   byte_out
);
  logic last_byte;

  assign last_byte  = data_re && (phase == PH_BLUE);
  assign fetch_en   = addr_we || last_byte;
  assign fetch_addr = addr_we ? addr_in : addr;

  always_comb begin
    unique case (phase)
      PH_RED:   byte_out = held[3*BW-1:2*BW];
      PH_GREEN: byte_out = held[2*BW-1:BW];
      default:  byte_out = held[BW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      phase <= PH_RED;
    end else if (addr_we) begin
      addr  <= addr_in + 1'b1;
      phase <= PH_RED;
    end else if (data_re) begin
      unique case (phase)
        PH_RED:   phase <= PH_GREEN;
        PH_GREEN: phase <= PH_BLUE;
        default: begin
          phase <= PH_RED;
          addr  <= addr + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/palette_port.sv
module palette_port
  import palette_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_cs,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic [1:0]      host_sel,
  input  logic [BW-1:0]   host_din,
  output logic [BW-1:0]   host_dout,
  input  logic [AW-1:0]   pix_index,
  output logic [3*BW-1:0] pix_color
);
  localparam int EW = 3 * BW;

  logic          wr_stb, rd_stb;
  logic          waddr_we, raddr_we, data_we, data_re;
  logic [AW-1:0] waddr, raddr, fetch_addr;
  phase_t        wphase, rphase;
  logic          ram_we, fetch_en;
  logic [EW-1:0] ram_wdata, held;
  logic [BW-1:0] rd_byte;

  assign wr_stb   = host_cs && host_wr;
  assign rd_stb   = host_cs && host_rd && !host_wr;
  assign waddr_we = wr_stb && (host_sel == SEL_WADDR);
  assign raddr_we = wr_stb && (host_sel == SEL_RADDR);
  assign data_we  = wr_stb && (host_sel == SEL_DATA);
  assign data_re  = rd_stb && (host_sel == SEL_DATA);

  palette_wr_gather #(.AW(AW), .BW(BW)) u_gather (
    .clk       (clk),
    .rst       (rst),
    .addr_we   (waddr_we),
    .addr_in   (host_din[AW-1:0]),
    .data_we   (data_we),
    .data_in   (host_din),
    .addr      (waddr),
    .phase     (wphase),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata)
  );

  palette_rd_prefetch #(.AW(AW), .BW(BW)) u_prefetch (
    .clk        (clk),
    .rst        (rst),
    .addr_we    (raddr_we),
    .addr_in    (host_din[AW-1:0]),
    .data_re    (data_re),
    .held       (held),
    .addr       (raddr),
    .phase      (rphase),
    .fetch_en   (fetch_en),
    .fetch_addr (fetch_addr),
    .byte_out   (rd_byte)
  );

  palette_ram #(.AW(AW), .DW(EW)) u_ram (
    .clk    (clk),
    .we     (ram_we),
    .w_addr (waddr),
    .w_data (ram_wdata),
    .a_en   (fetch_en),
    .a_addr (fetch_addr),
    .a_q    (held),
    .b_addr (pix_index),
    .b_q    (pix_color)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_dout <= '0;
    end else if (rd_stb) begin
      unique case (host_sel)
        SEL_WADDR: host_dout <= BW'(waddr);
        SEL_DATA:  host_dout <= rd_byte;
        SEL_RADDR: host_dout <= BW'(raddr);
        default:   host_dout <= '0;
      endcase
    end
  end
endmodule

// File: rtl/palette_port_checker.sv
module palette_port_checker #(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_cs,
  input logic          host_rd,
  input logic          host_wr,
  input logic [1:0]    host_sel,
  input logic [BW-1:0] host_din,
  input logic [BW-1:0] host_dout,
  input logic [AW-1:0] waddr,
  input logic [AW-1:0] raddr,
  input logic [1:0]    wphase,
  input logic [1:0]    rphase
);
  logic wr_s, rd_s;
  assign wr_s = host_cs && host_wr;
  assign rd_s = host_cs && host_rd && !host_wr;

  assert_phase_legal_R1: assert property (@(posedge clk) disable iff (rst)
    (wphase != 2'd3) && (rphase != 2'd3));

  assert_waddr_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_s && host_sel == 2'd0) |=> (waddr == $past(host_din[AW-1:0])));

  assert_waddr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_s && host_sel == 2'd1 && wphase == 2'd2) |=>
      (waddr == AW'($past(waddr) + 1'b1)) && (wphase == 2'd0));

  assert_partial_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_s && host_sel == 2'd0) |=> (wphase == 2'd0));

  assert_raddr_prefetch_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_s && host_sel == 2'd2) |=>
      (raddr == AW'($past(host_din[AW-1:0]) + 1'b1)) && (rphase == 2'd0));

  assert_rd_stream_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_s && host_sel == 2'd1 && rphase == 2'd2) |=>
      (raddr == AW'($past(raddr) + 1'b1)));

  assert_dout_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_s |=> $stable(host_dout));

  assert_reserved_inert_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_s && host_sel == 2'd3) |=>
      $stable(waddr) && $stable(raddr) && $stable(wphase) && $stable(rphase));
endmodule

bind palette_port palette_port_checker #(.AW(AW), .BW(BW)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .host_cs   (host_cs),
  .host_rd   (host_rd),
  .host_wr   (host_wr),
  .host_sel  (host_sel),
  .host_din  (host_din),
  .host_dout (host_dout),
  .waddr     (waddr),
  .raddr     (raddr),
  .wphase    (wphase),
  .rphase    (rphase)
);

// File: tb/palette_port_test.sv
module palette_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [7:0]  host_din = 8'd0;
  logic [7:0]  host_dout;
  logic [7:0]  pix_index = 8'd0;
  logic [23:0] pix_color;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  palette_port uut (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_rd(host_rd),
    .host_wr(host_wr), .host_sel(host_sel), .host_din(host_din),
    .host_dout(host_dout), .pix_index(pix_index), .pix_color(pix_color)
  );

  function automatic logic [23:0] color_of(input logic [7:0] i, input logic [7:0] salt);
    return {i ^ salt, i + 8'h11, ~i};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_wr = 1'b1; host_sel = sel; host_din = d;
    @(negedge clk);
    host_cs = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_rd = 1'b1; host_sel = sel;
    @(negedge clk);
    host_cs = 1'b0; host_rd = 1'b0;
    d = host_dout;
  endtask

  task automatic put_entry(input logic [23:0] c);
    wr(2'd1, c[23:16]);
    wr(2'd1, c[15:8]);
    wr(2'd1, c[7:0]);
  endtask

  task automatic look(input logic [7:0] idx, output logic [23:0] c);
    @(negedge clk);
    pix_index = idx;
    @(negedge clk);
    c = pix_color;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 dout after reset", host_dout, 8'd0);
    rd(2'd0, d); check("R1 write address after reset", d, 8'd0);
    rd(2'd2, d); check("R1 read address after reset", d, 8'd0);
  endtask

  task automatic t_waddr;
    logic [7:0] d;
    wr(2'd0, 8'h3C);
    rd(2'd0, d); check("R2 write address readback", d, 8'h3C);
  endtask

  task automatic t_stream_write;
    logic [7:0] d;
    logic [23:0] c;
    wr(2'd0, 8'd10);
    for (int i = 10; i < 13; i++) put_entry(color_of(8'(i), 8'h5A));
    rd(2'd0, d); check("R3 write address after three entries", d, 8'd13);
    for (int i = 10; i < 13; i++) begin
      look(8'(i), c);
      check("R3/R9 committed entry on lookup port", c, color_of(8'(i), 8'h5A));
    end
  endtask

  task automatic t_partial;
    logic [7:0] d;
    logic [23:0] c;
    wr(2'd0, 8'd20);
    put_entry(24'hA1B2C3);
    wr(2'd0, 8'd20);
    wr(2'd1, 8'hEE);
    wr(2'd1, 8'hDD);
    look(8'd20, c); check("R4 two bytes leave entry unchanged", c, 24'hA1B2C3);
    wr(2'd0, 8'd21);
    rd(2'd0, d); check("R4 write address after rewrite", d, 8'd21);
    put_entry(24'h102030);
    look(8'd21, c); check("R4 fresh entry without stale bytes", c, 24'h102030);
    look(8'd20, c); check("R4 earlier entry still intact", c, 24'hA1B2C3);
  endtask

  task automatic t_read_stream;
    logic [7:0] d;
    logic [23:0] e;
    wr(2'd2, 8'd10);
    rd(2'd2, d); check("R5 read address is loaded value plus one", d, 8'd11);
    for (int i = 10; i < 13; i++) begin
      e = color_of(8'(i), 8'h5A);
      rd(2'd1, d); check("R6 red byte", d, e[23:16]);
      rd(2'd1, d); check("R6 green byte", d, e[15:8]);
      rd(2'd1, d); check("R6 blue byte", d, e[7:0]);
    end
    rd(2'd2, d); check("R6 read address after streaming", d, 8'd14);
    wr(2'd2, 8'd11);
    rd(2'd1, d);
    wr(2'd2, 8'd12);
    e = color_of(8'd12, 8'h5A);
    rd(2'd1, d); check("R5 phase restarts at red on reload", d, e[23:16]);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    logic [23:0] e;
    wr(2'd0, 8'd255);
    put_entry(color_of(8'd255, 8'hC3));
    rd(2'd0, d); check("R7 write address wraps", d, 8'd0);
    put_entry(color_of(8'd0, 8'hC3));
    wr(2'd2, 8'd255);
    rd(2'd2, d); check("R7 read address wraps on load", d, 8'd0);
    e = color_of(8'd255, 8'hC3);
    rd(2'd1, d); check("R7 entry 255 red", d, e[23:16]);
    rd(2'd1, d);
    rd(2'd1, d); check("R7 entry 255 blue", d, e[7:0]);
    e = color_of(8'd0, 8'hC3);
    rd(2'd1, d); check("R7 entry 0 red after wrap", d, e[23:16]);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    wr(2'd2, 8'd20);
    rd(2'd1, d); check("R8 red of entry 20", d, 8'hA1);
    repeat (4) @(negedge clk);
    check("R8 dout holds while idle", host_dout, 8'hA1);
    wr(2'd1, 8'h77);
    check("R8 dout holds across a write", host_dout, 8'hA1);
    wr(2'd0, 8'd20);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    logic [23:0] c;
    wr(2'd0, 8'd40);
    wr(2'd2, 8'd41);
    wr(2'd3, 8'h99);
    rd(2'd3, d); check("R10 reserved reads zero", d, 8'd0);
    rd(2'd0, d); check("R10 write address untouched", d, 8'd40);
    rd(2'd2, d); check("R10 read address untouched", d, 8'd42);
    look(8'd20, c); check("R10 palette untouched", c, 24'hA1B2C3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_waddr;
    t_stream_write;
    t_partial;
    t_read_stream;
    t_wrap;
    t_hold;
    t_reserved;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule